// File: doc/BRIEF.md
# Shared egress buffer admission controller

This block makes the admit-or-drop decision for frames headed into egress queues that all share one buffer memory. It also keeps the occupancy books for that memory. Each port has a number of queues. Every queue is configured with four kinds of percentage: a share of a per-port block budget, a reserved fraction of that share, and three drop levels. The block turns these percentages into block and frame limits. Storage is counted in whole 256-byte blocks. A queue first uses its own guaranteed reservation. Once that is used up, it overflows into one common pool that every port of the chip draws from.

An enqueue request names a port, a queue, a drop class and a frame length in bytes. The answer appears on registered outputs one clock later, and the occupancy counters change on that same edge. A dequeue request names a port, a queue and a length, and gives the blocks back. A small configuration port writes the percentages. A read port returns one queue's block count, frame count and drop count. The current free level of the common pool is always visible on its own output.

Top module: `egbuf_admission`

## Requirements
- R1: A frame of L bytes occupies ceil(L/256) blocks. For example, lengths 64 and 250 take one block each and 257 takes two. The read port shows the queue's block total after admission.
- R2: A request with length 0 is always dropped. A request with drop class 3 is always dropped. Classes 0, 1 and 2 select drop level 0, 1 and 2.
- R3: The accept/drop result is valid on `enq_done`/`enq_accept` in the cycle after `enq_valid`, and `enq_done` is low in the following cycle when there is no new request.
- R4: A queue's frame cap is share × PORT_FRAMES / 100. With a full frame count, a further frame is dropped whatever its size.
- R5: A drop level in blocks is level% × share% × PORT_BLOCKS / 10000, and the reservation is resv% × share% × PORT_BLOCKS / 10000. A frame is dropped when occupancy plus its blocks would exceed the level chosen by its class.
- R6: Admitted blocks come from the queue's unused reservation first. Only the remainder lowers `pool_free`. While reserved blocks remain, a frame is admitted even when the pool is empty.
- R7: A frame is dropped when the blocks it needs beyond the unused reservation exceed `pool_free`.
- R8: A dequeue returns blocks to the common pool only for the part of the queue's occupancy above its reservation. It lowers the frame count by one.
- R9: When an enqueue and a dequeue target the same queue in one cycle, the dequeue is applied first and the enqueue is judged on the result.
- R10: A configuration write (field codes 0 = share, 1 = reservation, 2/3/4 = drop levels 0/1/2) is taken only if the queue holds no blocks and no frames, and no enqueue or dequeue targets that queue in the same cycle. `cfg_ok` reports the outcome one cycle later. A taken write recomputes the limits and moves `pool_free` by (old reservation − new reservation). A refused write changes no limit.
- R11: Every dropped enqueue adds one to that queue's drop counter, which the read port returns.
- R12: After reset, `pool_free` equals TOTAL_BLOCKS, all counters and limits are zero, and `pool_free` never exceeds TOTAL_BLOCKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue request strobe |
| enq_port | input | PW | Enqueue port number |
| enq_queue | input | QW | Enqueue queue number |
| enq_class | input | 2 | Drop class (0..2, 3 always drops) |
| enq_len | input | LEN_W | Frame length in bytes |
| deq_valid | input | 1 | Dequeue request strobe |
| deq_port | input | PW | Dequeue port number |
| deq_queue | input | QW | Dequeue queue number |
| deq_len | input | LEN_W | Length of the departing frame in bytes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | PW | Port of the written queue |
| cfg_queue | input | QW | Queue being written |
| cfg_field | input | 3 | Field code: 0 share, 1 reservation, 2..4 drop levels |
| cfg_data | input | PCT_W | Percentage value |
| rd_port | input | PW | Port for the statistics read |
| rd_queue | input | QW | Queue for the statistics read |
| enq_done | output | 1 | Decision valid |
| enq_accept | output | 1 | Frame admitted |
| cfg_done | output | 1 | Configuration write answered |
| cfg_ok | output | 1 | Configuration write taken |
| pool_free | output | BLK_W | Free blocks in the common pool |
| rd_blocks | output | BLK_W | Blocks held by the read queue |
| rd_frames | output | FRM_W | Frames held by the read queue |
| rd_drops | output | DROP_W | Drops counted for the read queue |

## Verification
An error in a queue's block count shows up at the ports in two ways. It changes where the reserved/common split falls, so `pool_free` moves by the wrong amount on the same edge as the admission or dequeue. It also makes a later decision come out differently at a threshold or pool boundary. The directed scenarios pin each count through the read port right after the operation. They also walk frames up to the exact level, frame cap and pool exhaustion points, so that an off-by-one in a comparison turns one accept into a drop, or the reverse, within one request. The same-cycle case and the refused configuration write are followed at once by an enqueue whose outcome depends on the state they should, or should not, have changed.

// File: rtl/egbuf_pkg.sv
package egbuf_pkg;

  typedef enum logic [2:0] {
    FLD_SHARE = 3'd0,
    FLD_RESV  = 3'd1,
    FLD_LVL0  = 3'd2,
    FLD_LVL1  = 3'd3,
    FLD_LVL2  = 3'd4
  } cfg_field_e;

  localparam int unsigned BLOCK_SHIFT = 8;

  // percentage of a percentage of a base amount, truncated
  function automatic logic [31:0] pct_scale(input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] base);
    return (a * b * base) / 32'd10000;
  endfunction

  function automatic logic [31:0] bytes_to_blocks(input logic [31:0] len);
    return (len + 32'd255) >> BLOCK_SHIFT;
  endfunction

endpackage

// File: rtl/egbuf_cfg_store.sv
module egbuf_cfg_store
  import egbuf_pkg::*;
#(
  parameter int unsigned NQT         = 16,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned PCT_W       = 9,
  parameter int unsigned BLK_W       = 13,
  parameter int unsigned FRM_W       = 12,
  parameter int unsigned PORT_BLOCKS = 200,
  parameter int unsigned PORT_FRAMES = 800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [2:0]       wr_field,
  input  logic [PCT_W-1:0] wr_data,
  output logic [BLK_W-1:0] rsv_lim [NQT],
  output logic [BLK_W-1:0] thr_lim [NQT][3],
  output logic [FRM_W-1:0] cap_lim [NQT],
  output logic [BLK_W-1:0] rsv_new
);

  logic [PCT_W-1:0] share_pct [NQT];
  logic [PCT_W-1:0] resv_pct  [NQT];
  logic [PCT_W-1:0] lvl_pct   [NQT][3];

  logic [PCT_W-1:0] n_share, n_resv;
  logic [PCT_W-1:0] n_lvl [3];
  logic [BLK_W-1:0] n_thr [3];
  logic [FRM_W-1:0] n_cap;

  // merged view of the written queue: new value for the addressed field
  always_comb begin
    n_share = (wr_field == FLD_SHARE) ? wr_data : share_pct[wr_idx];
    n_resv  = (wr_field == FLD_RESV)  ? wr_data : resv_pct[wr_idx];
    for (int k = 0; k < 3; k++) begin
      n_lvl[k] = (wr_field == 3'(k + 2)) ? wr_data : lvl_pct[wr_idx][k];
      n_thr[k] = BLK_W'(pct_scale(32'(n_lvl[k]), 32'(n_share), 32'(PORT_BLOCKS)));
    end
    rsv_new = BLK_W'(pct_scale(32'(n_resv), 32'(n_share), 32'(PORT_BLOCKS)));
    n_cap   = FRM_W'((32'(n_share) * 32'(PORT_FRAMES)) / 32'd100);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NQT; i++) begin
        share_pct[i] <= '0;
        resv_pct[i]  <= '0;
        rsv_lim[i]   <= '0;
        cap_lim[i]   <= '0;
        for (int k = 0; k < 3; k++) begin
          lvl_pct[i][k] <= '0;
          thr_lim[i][k] <= '0;
        end
      end
    end else if (wr_en) begin
      share_pct[wr_idx] <= n_share;
      resv_pct[wr_idx]  <= n_resv;
      rsv_lim[wr_idx]   <= rsv_new;
      cap_lim[wr_idx]   <= n_cap;
      for (int k = 0; k < 3; k++) begin
        lvl_pct[wr_idx][k] <= n_lvl[k];
        thr_lim[wr_idx][k] <= n_thr[k];
      end
    end
  end

endmodule

// File: rtl/egbuf_admit.sv
module egbuf_admit
  import egbuf_pkg::*;
#(
  parameter int unsigned BLK_W = 13,
  parameter int unsigned FRM_W = 12,
  parameter int unsigned LEN_W = 16
) (
  input  logic [BLK_W-1:0] used,
  input  logic [FRM_W-1:0] frames,
  input  logic [BLK_W-1:0] rsv,
  input  logic [BLK_W-1:0] thr,
  input  logic [FRM_W-1:0] cap,
  input  logic [BLK_W-1:0] pool,
  input  logic [LEN_W-1:0] len,
  input  logic             class_ok,
  output logic             ok,
  output logic [BLK_W-1:0] nblk,
  output logic [BLK_W-1:0] take
);

  logic [31:0] n32, u32, r32, spare, need;

  always_comb begin
    n32   = bytes_to_blocks(32'(len));
    u32   = 32'(used);
    r32   = 32'(rsv);
    spare = (r32 > u32) ? (r32 - u32) : 32'd0;
    need  = (n32 > spare) ? (n32 - spare) : 32'd0;
    ok    = class_ok && (len != '0) && (frames < cap) &&
            ((u32 + n32) <= 32'(thr)) && (need <= 32'(pool));
    nblk  = BLK_W'(n32);
    take  = ok ? BLK_W'(need) : '0;
  end

endmodule

// File: rtl/egbuf_release.sv
module egbuf_release
  import egbuf_pkg::*;
#(
  parameter int unsigned BLK_W = 13,
  parameter int unsigned FRM_W = 12,
  parameter int unsigned LEN_W = 16
) (
  input  logic             active,
  input  logic [BLK_W-1:0] used,
  input  logic [FRM_W-1:0] frames,
  input  logic [BLK_W-1:0] rsv,
  input  logic [LEN_W-1:0] len,
  output logic [BLK_W-1:0] used_next,
  output logic [FRM_W-1:0] frames_next,
  output logic [BLK_W-1:0] ret
);

  logic [31:0] n32, u32, r32, freed, over, back;

  always_comb begin
    n32   = bytes_to_blocks(32'(len));
    u32   = 32'(used);
    r32   = 32'(rsv);
    freed = (n32 < u32) ? n32 : u32;
    over  = (u32 > r32) ? (u32 - r32) : 32'd0;
    back  = (freed < over) ? freed : over;
    if (active) begin
      used_next   = BLK_W'(u32 - freed);
      frames_next = (frames != '0) ? (frames - FRM_W'(1)) : '0;
      ret         = BLK_W'(back);
    end else begin
      used_next   = used;
      frames_next = frames;
      ret         = '0;
    end
  end

endmodule

// File: rtl/egbuf_admission.sv
module egbuf_admission
  import egbuf_pkg::*;
#(
  parameter int unsigned NUM_PORTS    = 4,
  parameter int unsigned NUM_QUEUES   = 4,
  parameter int unsigned PORT_BLOCKS  = 200,
  parameter int unsigned TOTAL_BLOCKS = 7400,
  parameter int unsigned PORT_FRAMES  = 800,
  parameter int unsigned LEN_W        = 16,
  parameter int unsigned PCT_W        = 9,
  parameter int unsigned DROP_W       = 16,
  localparam int unsigned PW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned QW        = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int unsigned NQT       = NUM_PORTS * NUM_QUEUES,
  localparam int unsigned IDX_W     = (NQT > 1) ? $clog2(NQT) : 1,
  localparam int unsigned PCT_MAX   = (1 << PCT_W) - 1,
  localparam int unsigned LIM_BOUND = (PCT_MAX * PCT_MAX / 10000 + 1) * PORT_BLOCKS,
  localparam int unsigned BLK_W     = $clog2(((TOTAL_BLOCKS > LIM_BOUND) ? TOTAL_BLOCKS : LIM_BOUND) + 1),
  localparam int unsigned FRM_W     = $clog2(PCT_MAX * PORT_FRAMES / 100 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_valid,
  input  logic [PW-1:0]     enq_port,
  input  logic [QW-1:0]     enq_queue,
  input  logic [1:0]        enq_class,
  input  logic [LEN_W-1:0]  enq_len,
  input  logic              deq_valid,
  input  logic [PW-1:0]     deq_port,
  input  logic [QW-1:0]     deq_queue,
  input  logic [LEN_W-1:0]  deq_len,
  input  logic              cfg_we,
  input  logic [PW-1:0]     cfg_port,
  input  logic [QW-1:0]     cfg_queue,
  input  logic [2:0]        cfg_field,
  input  logic [PCT_W-1:0]  cfg_data,
  input  logic [PW-1:0]     rd_port,
  input  logic [QW-1:0]     rd_queue,
  output logic              enq_done,
  output logic              enq_accept,
  output logic              cfg_done,
  output logic              cfg_ok,
  output logic [BLK_W-1:0]  pool_free,
  output logic [BLK_W-1:0]  rd_blocks,
  output logic [FRM_W-1:0]  rd_frames,
  output logic [DROP_W-1:0] rd_drops
);

  function automatic logic [IDX_W-1:0] flat(input logic [PW-1:0] p, input logic [QW-1:0] q);
    return IDX_W'(32'(p) * NUM_QUEUES + 32'(q));
  endfunction

  // per-queue occupancy state
  logic [BLK_W-1:0]  blk_q  [NQT];
  logic [FRM_W-1:0]  frm_q  [NQT];
  logic [DROP_W-1:0] drop_q [NQT];
  logic [BLK_W-1:0]  pool_q;

  // derived limits
  logic [BLK_W-1:0] rsv_lim [NQT];
  logic [BLK_W-1:0] thr_lim [NQT][3];
  logic [FRM_W-1:0] cap_lim [NQT];
  logic [BLK_W-1:0] rsv_new;

  logic [IDX_W-1:0] d_idx, e_idx, c_idx, r_idx;
  logic [BLK_W-1:0] d_used_next, d_ret;
  logic [FRM_W-1:0] d_frm_next;
  logic             e_same;
  logic [BLK_W-1:0] e_used, pool_mid, thr_sel, avail, pool_next;
  logic [FRM_W-1:0] e_frm;
  logic             class_ok, a_ok, enq_ok;
  logic [BLK_W-1:0] a_nblk, a_take;
  logic             c_busy, c_empty, c_fit, c_ok;

  assign d_idx = flat(deq_port, deq_queue);
  assign e_idx = flat(enq_port, enq_queue);
  assign c_idx = flat(cfg_port, cfg_queue);
  assign r_idx = flat(rd_port, rd_queue);

  egbuf_cfg_store #(
    .NQT(NQT), .IDX_W(IDX_W), .PCT_W(PCT_W), .BLK_W(BLK_W), .FRM_W(FRM_W),
    .PORT_BLOCKS(PORT_BLOCKS), .PORT_FRAMES(PORT_FRAMES)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(c_ok), .wr_idx(c_idx), .wr_field(cfg_field),
    .wr_data(cfg_data), .rsv_lim(rsv_lim), .thr_lim(thr_lim), .cap_lim(cap_lim),
    .rsv_new(rsv_new)
  );

  // dequeue is resolved first
  egbuf_release #(.BLK_W(BLK_W), .FRM_W(FRM_W), .LEN_W(LEN_W)) u_rel (
    .active(deq_valid), .used(blk_q[d_idx]), .frames(frm_q[d_idx]), .rsv(rsv_lim[d_idx]),
    .len(deq_len), .used_next(d_used_next), .frames_next(d_frm_next), .ret(d_ret)
  );

  always_comb begin
    e_same   = deq_valid && (d_idx == e_idx);
    e_used   = e_same ? d_used_next : blk_q[e_idx];
    e_frm    = e_same ? d_frm_next  : frm_q[e_idx];
    pool_mid = pool_q + d_ret;
    class_ok = (enq_class != 2'd3);
    thr_sel  = thr_lim[e_idx][class_ok ? enq_class : 2'd0];
  end

  egbuf_admit #(.BLK_W(BLK_W), .FRM_W(FRM_W), .LEN_W(LEN_W)) u_adm (
    .used(e_used), .frames(e_frm), .rsv(rsv_lim[e_idx]), .thr(thr_sel), .cap(cap_lim[e_idx]),
    .pool(pool_mid), .len(enq_len), .class_ok(class_ok),
    .ok(a_ok), .nblk(a_nblk), .take(a_take)
  );

  always_comb begin
    enq_ok    = enq_valid && a_ok;
    avail     = pool_mid - (enq_ok ? a_take : '0);
    c_busy    = (enq_valid && (e_idx == c_idx)) || (deq_valid && (d_idx == c_idx));
    c_empty   = (blk_q[c_idx] == '0) && (frm_q[c_idx] == '0);
    c_fit     = 32'(rsv_new) <= (32'(avail) + 32'(rsv_lim[c_idx]));
    c_ok      = cfg_we && c_empty && !c_busy && c_fit;
    pool_next = c_ok ? BLK_W'(32'(avail) + 32'(rsv_lim[c_idx]) - 32'(rsv_new)) : avail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NQT; i++) begin
        blk_q[i]  <= '0;
        frm_q[i]  <= '0;
        drop_q[i] <= '0;
      end
      pool_q     <= BLK_W'(TOTAL_BLOCKS);
      enq_done   <= 1'b0;
      enq_accept <= 1'b0;
      cfg_done   <= 1'b0;
      cfg_ok     <= 1'b0;
      rd_blocks  <= '0;
      rd_frames  <= '0;
      rd_drops   <= '0;
    end else begin
      if (deq_valid) begin
        blk_q[d_idx] <= d_used_next;
        frm_q[d_idx] <= d_frm_next;
      end
      if (enq_valid) begin
        if (a_ok) begin
          blk_q[e_idx] <= e_used + a_nblk;
          frm_q[e_idx] <= e_frm + FRM_W'(1);
        end else begin
          drop_q[e_idx] <= drop_q[e_idx] + DROP_W'(1);
        end
      end
      pool_q     <= pool_next;
      enq_done   <= enq_valid;
      enq_accept <= enq_ok;
      cfg_done   <= cfg_we;
      cfg_ok     <= c_ok;
      rd_blocks  <= blk_q[r_idx];
      rd_frames  <= frm_q[r_idx];
      rd_drops   <= drop_q[r_idx];
    end
  end

  assign pool_free = pool_q;

endmodule

// File: rtl/egbuf_admission_chk.sv
module egbuf_admission_chk #(
  parameter int unsigned TOTAL_BLOCKS = 7400,
  parameter int unsigned BLK_W        = 13,
  parameter int unsigned LEN_W        = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enq_valid,
  input logic [1:0]       enq_class,
  input logic [LEN_W-1:0] enq_len,
  input logic             deq_valid,
  input logic             cfg_we,
  input logic             enq_done,
  input logic             enq_accept,
  input logic             cfg_done,
  input logic [BLK_W-1:0] pool_free
);

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
    enq_valid |=> enq_done);

  assert_accept_has_done_R3: assert property (@(posedge clk) disable iff (rst)
    enq_accept |-> enq_done);

  assert_bad_request_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && ((enq_len == '0) || (enq_class == 2'd3))) |=> !enq_accept);

  assert_pool_bound_R12: assert property (@(posedge clk) disable iff (rst)
    32'(pool_free) <= TOTAL_BLOCKS);

  assert_pool_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!enq_valid && !deq_valid && !cfg_we) |=> $stable(pool_free));

  assert_pool_no_loss_R7: assert property (@(posedge clk) disable iff (rst)
    (!enq_valid && !cfg_we) |=> (pool_free >= $past(pool_free)));

  assert_cfg_answer_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_done);

endmodule

bind egbuf_admission egbuf_admission_chk #(
  .TOTAL_BLOCKS(TOTAL_BLOCKS), .BLK_W(BLK_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_class(enq_class), .enq_len(enq_len),
  .deq_valid(deq_valid), .cfg_we(cfg_we), .enq_done(enq_done), .enq_accept(enq_accept),
  .cfg_done(cfg_done), .pool_free(pool_free)
);

// File: tb/egbuf_admission_test.sv
module egbuf_admission_test;

  localparam int TOTAL = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        enq_valid = 0, deq_valid = 0, cfg_we = 0;
  logic [0:0]  enq_port = 0, deq_port = 0, cfg_port = 0, rd_port = 0;
  logic [1:0]  enq_queue = 0, deq_queue = 0, cfg_queue = 0, rd_queue = 0;
  logic [1:0]  enq_class = 0;
  logic [15:0] enq_len = 0, deq_len = 0;
  logic [2:0]  cfg_field = 0;
  logic [8:0]  cfg_data = 0;
  logic        enq_done, enq_accept, cfg_done, cfg_ok;
  logic [12:0] pool_free, rd_blocks;
  logic [11:0] rd_frames;
  logic [15:0] rd_drops;

  egbuf_admission #(
    .NUM_PORTS(2), .NUM_QUEUES(4), .PORT_BLOCKS(200), .TOTAL_BLOCKS(TOTAL),
    .PORT_FRAMES(800), .LEN_W(16), .PCT_W(9), .DROP_W(16)
  ) uut (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_port(enq_port), .enq_queue(enq_queue),
    .enq_class(enq_class), .enq_len(enq_len),
    .deq_valid(deq_valid), .deq_port(deq_port), .deq_queue(deq_queue), .deq_len(deq_len),
    .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_queue(cfg_queue),
    .cfg_field(cfg_field), .cfg_data(cfg_data),
    .rd_port(rd_port), .rd_queue(rd_queue),
    .enq_done(enq_done), .enq_accept(enq_accept), .cfg_done(cfg_done), .cfg_ok(cfg_ok),
    .pool_free(pool_free), .rd_blocks(rd_blocks), .rd_frames(rd_frames), .rd_drops(rd_drops)
  );

  int checks = 0;
  int errs = 0;
  bit finished = 0;

  task automatic expect_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_enq(input int p, input int q, input int cls, input int len,
                        input int exp_acc, input string tag);
    @(negedge clk);
    enq_valid = 1; enq_port = 1'(p); enq_queue = 2'(q); enq_class = 2'(cls); enq_len = 16'(len);
    @(negedge clk);
    enq_valid = 0;
    expect_eq({tag, " accept"}, int'(enq_accept), exp_acc);
  endtask

  task automatic do_deq(input int p, input int q, input int len);
    @(negedge clk);
    deq_valid = 1; deq_port = 1'(p); deq_queue = 2'(q); deq_len = 16'(len);
    @(negedge clk);
    deq_valid = 0;
  endtask

  task automatic do_cfg(input int p, input int q, input int f, input int d,
                        input int exp_ok, input string tag);
    @(negedge clk);
    cfg_we = 1; cfg_port = 1'(p); cfg_queue = 2'(q); cfg_field = 3'(f); cfg_data = 9'(d);
    @(negedge clk);
    cfg_we = 0;
    expect_eq({tag, " cfg_ok"}, int'(cfg_ok), exp_ok);
  endtask

  task automatic read_q(input int p, input int q, output int b, output int f, output int d);
    @(negedge clk);
    rd_port = 1'(p); rd_queue = 2'(q);
    @(negedge clk);
    b = int'(rd_blocks); f = int'(rd_frames); d = int'(rd_drops);
  endtask

  // R12: reset state
  task automatic t_reset();
    int b, f, d;
    expect_eq("R12 pool at reset", int'(pool_free), TOTAL);
    expect_eq("R12 no decision at reset", int'(enq_done), 0);
    read_q(0, 0, b, f, d);
    expect_eq("R12 blocks zero", b, 0);
    expect_eq("R12 drops zero", d, 0);
  endtask

  // R5/R10: limits from percentages; reservation 50% of 10% of 200 = 10
  task automatic t_setup();
    do_cfg(0, 0, 0, 10, 1, "R10 share");
    do_cfg(0, 0, 1, 50, 1, "R10 resv");
    expect_eq("R10 pool after reservation", int'(pool_free), TOTAL - 10);
    do_cfg(0, 0, 2, 100, 1, "R5 lvl0");
    do_cfg(0, 0, 3, 200, 1, "R5 lvl1");
    do_cfg(0, 0, 4, 500, 1, "R5 lvl2");
  endtask

  // R1/R6: rounding to blocks, reserved blocks used first
  task automatic t_blocks();
    int b, f, d;
    do_enq(0, 0, 0, 64, 1, "R1 64B");
    do_enq(0, 0, 0, 250, 1, "R1 250B");
    do_enq(0, 0, 0, 257, 1, "R1 257B");
    read_q(0, 0, b, f, d);
    expect_eq("R1 block total", b, 4);
    expect_eq("R6 pool untouched inside reservation", int'(pool_free), 54);
    do_enq(0, 0, 0, 16 * 256, 1, "R5 exactly at level0");
    expect_eq("R6 overflow drawn from pool", int'(pool_free), 44);
  endtask

  // R5/R2: threshold selection and bad requests
  task automatic t_threshold();
    do_enq(0, 0, 0, 1, 0, "R5 over level0");
    do_enq(0, 0, 1, 1, 1, "R5 class1 higher level");
    expect_eq("R6 pool after class1", int'(pool_free), 43);
    do_enq(0, 0, 1, 0, 0, "R2 zero length");
    do_enq(0, 0, 3, 1, 0, "R2 class3");
  endtask

  // R8: dequeue returns only the over-reservation part
  task automatic t_release();
    int b, f, d;
    do_deq(0, 0, 16 * 256);
    expect_eq("R8 pool after dequeue", int'(pool_free), 54);
    read_q(0, 0, b, f, d);
    expect_eq("R8 blocks after dequeue", b, 5);
    expect_eq("R8 frames after dequeue", f, 4);
  endtask

  // R7: pool exhaustion; R6 reservation still usable
  task automatic t_pool_limit();
    do_cfg(1, 0, 0, 100, 1, "R7 share");
    do_cfg(1, 0, 4, 500, 1, "R7 lvl2");
    do_enq(1, 0, 2, 54 * 256, 1, "R7 takes whole pool");
    expect_eq("R7 pool empty", int'(pool_free), 0);
    do_enq(1, 0, 2, 1, 0, "R7 pool exhausted");
    do_enq(0, 0, 1, 1, 1, "R6 reserved while pool empty");
    expect_eq("R6 pool still empty", int'(pool_free), 0);
    do_deq(1, 0, 54 * 256);
    expect_eq("R8 pool refilled", int'(pool_free), 54);
  endtask

  // R4: share 1% -> cap 8 frames, level2 500% -> 10 blocks
  task automatic t_frame_cap();
    do_cfg(1, 1, 0, 1, 1, "R4 share");
    do_cfg(1, 1, 4, 500, 1, "R4 lvl2");
    for (int i = 0; i < 8; i++) do_enq(1, 1, 2, 1, 1, "R4 under cap");
    expect_eq("R4 pool after eight", int'(pool_free), 46);
    do_enq(1, 1, 2, 1, 0, "R4 at frame cap");
  endtask

  // R9: dequeue before enqueue on the same queue
  task automatic t_same_cycle();
    int b, f, d;
    @(negedge clk);
    deq_valid = 1; deq_port = 1; deq_queue = 1; deq_len = 1;
    enq_valid = 1; enq_port = 1; enq_queue = 1; enq_class = 2; enq_len = 1;
    @(negedge clk);
    deq_valid = 0; enq_valid = 0;
    expect_eq("R9 enqueue sees dequeue", int'(enq_accept), 1);
    expect_eq("R9 pool balanced", int'(pool_free), 46);
    read_q(1, 1, b, f, d);
    expect_eq("R9 frames", f, 8);
    expect_eq("R9 blocks", b, 8);
  endtask

  // R10: writes only to empty queues, reservation moves the pool
  task automatic t_cfg_guard();
    do_cfg(1, 1, 0, 100, 0, "R10 busy queue refused");
    do_enq(1, 1, 2, 1, 0, "R10 cap unchanged after refusal");
    do_cfg(0, 2, 0, 20, 1, "R10 empty share");
    expect_eq("R10 pool unchanged by share", int'(pool_free), 46);
    do_cfg(0, 2, 1, 60, 1, "R10 empty resv");
    expect_eq("R10 pool minus 24", int'(pool_free), 22);
  endtask

  // R11: drop counters
  task automatic t_drops();
    int b, f, d;
    read_q(0, 0, b, f, d);
    expect_eq("R11 p0q0 drops", d, 3);
    read_q(1, 0, b, f, d);
    expect_eq("R11 p1q0 drops", d, 1);
    read_q(1, 1, b, f, d);
    expect_eq("R11 p1q1 drops", d, 2);
    read_q(0, 1, b, f, d);
    expect_eq("R11 p0q1 drops", d, 0);
  endtask

  // R3: one-cycle decision, no decision without request
  task automatic t_latency();
    @(negedge clk);
    enq_valid = 1; enq_port = 0; enq_queue = 3; enq_class = 0; enq_len = 100;
    @(negedge clk);
    enq_valid = 0;
    expect_eq("R3 done one cycle later", int'(enq_done), 1);
    @(negedge clk);
    expect_eq("R3 done drops after", int'(enq_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_setup();
    t_blocks();
    t_threshold();
    t_release();
    t_pool_limit();
    t_frame_cap();
    t_same_cycle();
    t_cfg_guard();
    t_drops();
    t_latency();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errs++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule